// File: doc/BRIEF.md
# Codec Command Slot Interface

This block is the command side of an audio-link controller. Software reaches the control registers of an attached codec through two slot registers. The command slot holds a 7-bit codec register address and a direction flag. The data slot holds a 16-bit value that is placed in the upper part of a 20-bit field.

Writing the command slot starts one access on a synchronous codec request port. The access is a single-cycle strobe carrying the address, the write data and a read enable. For a read, the codec answers on the cycle after the strobe. The block then places the echoed command and the shifted result in two receive registers.

A flag register reports transmit-empty, receive-busy and receive-valid state for the slots. Reading a receive register acknowledges it by clearing its valid flag.

Top module: `codec_cmd_slot`

Software register selects (`reg_sel_i`): 0 command slot, 1 data slot, 2 command echo receive, 3 data receive, 4 flags. Any other select reads as zero and ignores writes.

## Requirements
- R1: After reset the flag register (select 4) reads 0xA80, meaning bits 7, 9 and 11 are set. Both receive registers read 0 and `codec_req_o` is low.
- R2: A write to the data slot (select 1) stores the 20-bit value, which reads back at select 1, and clears flag bit 9.
- R3: An accepted write to the command slot (select 0) clears flag bit 7. It drives `codec_req_o` high for exactly the one cycle that follows the write edge.
- R4: During the strobe, `codec_addr_o` equals command bits [18:12] and `codec_rd_o` equals command bit 19, where 1 means read and 0 means write.
- R5: During a write strobe, `codec_wdata_o` equals data-slot bits [19:4].
- R6: For a read, the edge two cycles after the command write loads two values. Select 2 receives the command with bit 19 cleared. Select 3 receives the 16-bit codec response shifted left by 4.
- R7: An accepted read command sets flag bits 0 and 2 (receive busy) at its write edge. The capture edge clears them and sets bits 6 and 8 (receive valid).
- R8: Reading select 2 clears flag bit 6, and reading select 3 clears flag bit 8. If a capture falls on the same edge, the valid flag stays set.
- R9: A command write that arrives while an access is in flight is ignored. In flight means the strobe cycle or, for a read, the cycle that waits for the response. An ignored write produces no strobe and leaves the command slot unchanged.
- R10: Flag bits 7 and 9 return to 1 only through reset. Flag bit 11 is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (clears valid on the receive selects) |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 20 | Register write data |
| reg_rdata_o | output | 20 | Read data for the current select (combinational) |
| codec_req_o | output | 1 | One-cycle codec access strobe |
| codec_rd_o | output | 1 | Access is a read |
| codec_addr_o | output | 7 | Codec register address |
| codec_wdata_o | output | 16 | Codec write data |
| codec_rdata_i | input | 16 | Codec read response, valid the cycle after the strobe |

## Verification
Each result has a fixed delay from its stimulus:
- A slot write changes the stored value and the transmit-empty flag at its own edge.
- The codec strobe is visible in the cycle that follows that edge.
- Read results and valid flags land two edges after the command edge.
- A receive read clears its valid flag at the read edge.

The bench drives inputs on the falling edge and steps its reference model on the rising edge. It compares the strobe, address, direction, write data and the read mux shortly after each falling edge. Its directed checks sample exactly at the falling edge that follows the edge where each result is due. This includes commands that are blocked in both in-flight cycles, and a receive read that coincides with a capture.

// File: rtl/codec_slot_pkg.sv
package codec_slot_pkg;

  typedef enum logic [2:0] {
    SEL_CMD   = 3'd0,
    SEL_DATA  = 3'd1,
    SEL_RX1   = 3'd2,
    SEL_RX2   = 3'd3,
    SEL_FLAGS = 3'd4
  } reg_sel_e;

  localparam int unsigned FLAG_W          = 12;
  localparam int unsigned FLG_RX1_BUSY    = 0;
  localparam int unsigned FLG_RX2_BUSY    = 2;
  localparam int unsigned FLG_RX1_VALID   = 6;
  localparam int unsigned FLG_TX1_EMPTY   = 7;
  localparam int unsigned FLG_RX2_VALID   = 8;
  localparam int unsigned FLG_TX2_EMPTY   = 9;
  localparam int unsigned FLG_TX12_EMPTY  = 11;

endpackage

// File: rtl/codec_slot_issue.sv
module codec_slot_issue #(
  parameter int unsigned SLOT_W   = 20,
  parameter int unsigned CODEC_AW = 7,
  parameter int unsigned CODEC_DW = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_we_i,
  input  logic [SLOT_W-1:0]   cmd_wdata_i,
  input  logic [CODEC_DW-1:0] data_i,
  output logic [SLOT_W-1:0]   cmd_o,
  output logic                cmd_acc_o,
  output logic                rd_issue_o,
  output logic                capture_o,
  output logic                req_o,
  output logic                rd_o,
  output logic [CODEC_AW-1:0] addr_o,
  output logic [CODEC_DW-1:0] wdata_o
);
  localparam int unsigned RD_BIT   = SLOT_W - 1;
  localparam int unsigned ADDR_LSB = RD_BIT - CODEC_AW;

  logic                req_q, rd_q, wait_q;
  logic [SLOT_W-1:0]   cmd_q;
  logic [CODEC_AW-1:0] addr_q;
  logic [CODEC_DW-1:0] wd_q;
  logic                in_flight, accept;

  // a read stays in flight until its response is captured
  assign in_flight = req_q | wait_q;
  assign accept    = cmd_we_i & ~in_flight;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      rd_q   <= 1'b0;
      wait_q <= 1'b0;
      cmd_q  <= '0;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      req_q  <= accept;
      wait_q <= req_q & rd_q;
      if (accept) begin
        cmd_q  <= cmd_wdata_i;
        rd_q   <= cmd_wdata_i[RD_BIT];
        addr_q <= cmd_wdata_i[RD_BIT-1:ADDR_LSB];
        wd_q   <= data_i;
      end
    end
  end

  assign cmd_o      = cmd_q;
  assign cmd_acc_o  = accept;
  assign rd_issue_o = accept & cmd_wdata_i[RD_BIT];
  assign capture_o  = wait_q;
  assign req_o      = req_q;
  assign rd_o       = rd_q;
  assign addr_o     = addr_q;
  assign wdata_o    = wd_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q); // R3
  AST_CMD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q |-> ($stable(addr_q) && $stable(cmd_q))); // R9

endmodule

// File: rtl/codec_slot_rx.sv
module codec_slot_rx #(
  parameter int unsigned SLOT_W   = 20,
  parameter int unsigned CODEC_DW = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                capture_i,
  input  logic [SLOT_W-1:0]   cmd_i,
  input  logic [CODEC_DW-1:0] codec_rdata_i,
  output logic [SLOT_W-1:0]   rx1_o,
  output logic [SLOT_W-1:0]   rx2_o
);
  localparam int unsigned RD_BIT   = SLOT_W - 1;
  localparam int unsigned DATA_LSB = SLOT_W - CODEC_DW;

  logic [SLOT_W-1:0] echo;

  always_comb begin
    echo         = cmd_i;
    echo[RD_BIT] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx1_o <= '0;
      rx2_o <= '0;
    end else if (capture_i) begin
      rx1_o <= echo;
      rx2_o <= {codec_rdata_i, {DATA_LSB{1'b0}}};
    end
  end

endmodule

// File: rtl/codec_slot_flags.sv
module codec_slot_flags
  import codec_slot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_acc_i,
  input  logic              data_wr_i,
  input  logic              rd_issue_i,
  input  logic              capture_i,
  input  logic              rx1_rd_i,
  input  logic              rx2_rd_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic tx1_empty, tx2_empty, busy1, busy2, valid1, valid2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx1_empty <= 1'b1;
      tx2_empty <= 1'b1;
      busy1     <= 1'b0;
      busy2     <= 1'b0;
      valid1    <= 1'b0;
      valid2    <= 1'b0;
    end else begin
      if (cmd_acc_i) tx1_empty <= 1'b0;
      if (data_wr_i) tx2_empty <= 1'b0;
      if (rd_issue_i) begin
        busy1 <= 1'b1;
        busy2 <= 1'b1;
      end
      // capture outranks a same-edge acknowledge
      if (capture_i) begin
        busy1  <= 1'b0;
        busy2  <= 1'b0;
        valid1 <= 1'b1;
        valid2 <= 1'b1;
      end else begin
        if (rx1_rd_i) valid1 <= 1'b0;
        if (rx2_rd_i) valid2 <= 1'b0;
      end
    end
  end

  always_comb begin
    flags_o                 = '0;
    flags_o[FLG_RX1_BUSY]   = busy1;
    flags_o[FLG_RX2_BUSY]   = busy2;
    flags_o[FLG_RX1_VALID]  = valid1;
    flags_o[FLG_TX1_EMPTY]  = tx1_empty;
    flags_o[FLG_RX2_VALID]  = valid2;
    flags_o[FLG_TX2_EMPTY]  = tx2_empty;
    flags_o[FLG_TX12_EMPTY] = 1'b1;
  end

  AST_CAPTURE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (valid1 && valid2 && !busy1 && !busy2)); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx1_rd_i && !capture_i) |=> !valid1); // R8
  AST_TX_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx1_empty |=> !tx1_empty); // R10

endmodule

// File: rtl/codec_cmd_slot.sv
module codec_cmd_slot
  import codec_slot_pkg::*;
#(
  parameter int unsigned SLOT_W   = 20,
  parameter int unsigned CODEC_AW = 7,
  parameter int unsigned CODEC_DW = 16,
  parameter int unsigned SEL_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic                reg_re_i,
  input  logic [SEL_W-1:0]    reg_sel_i,
  input  logic [SLOT_W-1:0]   reg_wdata_i,
  output logic [SLOT_W-1:0]   reg_rdata_o,
  output logic                codec_req_o,
  output logic                codec_rd_o,
  output logic [CODEC_AW-1:0] codec_addr_o,
  output logic [CODEC_DW-1:0] codec_wdata_o,
  input  logic [CODEC_DW-1:0] codec_rdata_i
);
  localparam int unsigned DATA_LSB = SLOT_W - CODEC_DW;
  localparam int unsigned ADDR_LSB = SLOT_W - 1 - CODEC_AW;

  logic [SLOT_W-1:0] data_q, cmd_q, rx1_q, rx2_q;
  logic [FLAG_W-1:0] flags;
  logic              cmd_we, data_we, rx1_rd, rx2_rd;
  logic              cmd_acc, rd_issue, capture;

  assign cmd_we  = reg_we_i && (reg_sel_i == SEL_CMD);
  assign data_we = reg_we_i && (reg_sel_i == SEL_DATA);
  assign rx1_rd  = reg_re_i && (reg_sel_i == SEL_RX1);
  assign rx2_rd  = reg_re_i && (reg_sel_i == SEL_RX2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (data_we) data_q <= reg_wdata_i;
  end

  codec_slot_issue #(
    .SLOT_W(SLOT_W), .CODEC_AW(CODEC_AW), .CODEC_DW(CODEC_DW)
  ) u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_we_i    (cmd_we),
    .cmd_wdata_i (reg_wdata_i),
    .data_i      (data_q[SLOT_W-1:DATA_LSB]),
    .cmd_o       (cmd_q),
    .cmd_acc_o   (cmd_acc),
    .rd_issue_o  (rd_issue),
    .capture_o   (capture),
    .req_o       (codec_req_o),
    .rd_o        (codec_rd_o),
    .addr_o      (codec_addr_o),
    .wdata_o     (codec_wdata_o)
  );

  codec_slot_rx #(
    .SLOT_W(SLOT_W), .CODEC_DW(CODEC_DW)
  ) u_rx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .capture_i     (capture),
    .cmd_i         (cmd_q),
    .codec_rdata_i (codec_rdata_i),
    .rx1_o         (rx1_q),
    .rx2_o         (rx2_q)
  );

  codec_slot_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_acc_i  (cmd_acc),
    .data_wr_i  (data_we),
    .rd_issue_i (rd_issue),
    .capture_i  (capture),
    .rx1_rd_i   (rx1_rd),
    .rx2_rd_i   (rx2_rd),
    .flags_o    (flags)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_sel_i)
      SEL_CMD:   reg_rdata_o = cmd_q;
      SEL_DATA:  reg_rdata_o = data_q;
      SEL_RX1:   reg_rdata_o = rx1_q;
      SEL_RX2:   reg_rdata_o = rx2_q;
      SEL_FLAGS: reg_rdata_o = SLOT_W'(flags);
      default:   reg_rdata_o = '0;
    endcase
  end

  AST_BUSY_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags[FLG_RX1_BUSY] |-> ((codec_req_o && codec_rd_o) || capture)); // R7
  AST_RX1_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |=> (rx1_q[SLOT_W-2:ADDR_LSB] == codec_addr_o)); // R6
  AST_WR_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (codec_req_o && !codec_rd_o && !$past(data_we)) |-> (codec_wdata_o == data_q[SLOT_W-1:DATA_LSB])); // R5

endmodule

// File: tb/sim_codec_cmd_slot.sv
module sim_codec_cmd_slot;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  sel = 3'd0;
  logic [19:0] wdata = '0;
  logic [19:0] rdata;
  logic        req, rd;
  logic [6:0]  addr;
  logic [15:0] cwd;
  logic [15:0] resp = '0;
  logic [15:0] mem [128];

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  codec_cmd_slot u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .codec_req_o(req), .codec_rd_o(rd), .codec_addr_o(addr),
    .codec_wdata_o(cwd), .codec_rdata_i(resp)
  );

  // codec register file responder
  always @(posedge clk) begin
    if (req) begin
      if (!rd) mem[addr] <= cwd;
      else     resp <= mem[addr];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit          m_ok = 1'b0;
  bit          m_req, m_rd, m_wait;
  bit          m_t1, m_t2, m_b, m_v1, m_v2;
  logic [6:0]  m_addr;
  logic [15:0] m_wd;
  logic [19:0] m_cmd, m_data, m_rx1, m_rx2;

  function automatic logic [19:0] m_flags();
    return 20'h800 | (m_t2 ? 20'h200 : 0) | (m_v2 ? 20'h100 : 0) |
           (m_t1 ? 20'h080 : 0) | (m_v1 ? 20'h040 : 0) | (m_b ? 20'h005 : 0);
  endfunction

  function automatic logic [19:0] m_read(input logic [2:0] s);
    case (s)
      3'd0: return m_cmd;
      3'd1: return m_data;
      3'd2: return m_rx1;
      3'd3: return m_rx2;
      3'd4: return m_flags();
      default: return 20'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ok = 1'b1; m_req = 0; m_rd = 0; m_wait = 0; m_t1 = 1; m_t2 = 1;
      m_b = 0; m_v1 = 0; m_v2 = 0; m_addr = 0; m_wd = 0;
      m_cmd = 0; m_data = 0; m_rx1 = 0; m_rx2 = 0;
    end else begin
      bit busy_now, nwait, take;
      busy_now = m_req || m_wait;
      nwait = m_req && m_rd;
      if (m_wait) begin
        m_rx1 = m_cmd & ~20'h80000;
        m_rx2 = {mem[m_addr], 4'h0};
        m_b = 0; m_v1 = 1; m_v2 = 1;
      end else begin
        if (re && sel == 3'd2) m_v1 = 0;
        if (re && sel == 3'd3) m_v2 = 0;
      end
      take = we && sel == 3'd0 && !busy_now;
      m_req = take;
      if (take) begin
        m_cmd = wdata; m_rd = wdata[19]; m_addr = wdata[18:12];
        m_wd = m_data[19:4]; m_t1 = 0;
        if (wdata[19]) m_b = 1;
      end
      if (we && sel == 3'd1) begin m_data = wdata; m_t2 = 0; end
      m_wait = nwait;
    end
  end

  always @(negedge clk) begin
    #2;
    if (m_ok && rst_n && !done) begin
      chk("R3 strobe vs model", req, m_req);
      if (m_req) begin
        chk("R4 addr vs model", addr, m_addr);
        chk("R4 dir vs model", rd, m_rd);
        if (!m_rd) chk("R5 wdata vs model", cwd, m_wd);
      end
      chk("R6 R7 readmux vs model", rdata, m_read(sel));
    end
  end

  task automatic wr(input logic [2:0] s, input logic [19:0] v);
    sel = s; wdata = v; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic peek(input logic [2:0] s, output logic [19:0] v);
    sel = s; re = 1'b0; #1; v = rdata;
  endtask

  task automatic ack(input logic [2:0] s, output logic [19:0] v);
    sel = s; re = 1'b1; #1; v = rdata;
    @(posedge clk); @(negedge clk);
    re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [19:0] v;
    logic [15:0] e10;
    for (int i = 0; i < 128; i++) mem[i] = 16'(i * 515) ^ 16'h5A5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    peek(3'd4, v); chk("R1 flags", v, 20'hA80);
    peek(3'd2, v); chk("R1 rx1", v, 0);
    peek(3'd3, v); chk("R1 rx2", v, 0);
    chk("R1 strobe", req, 0);

    // R2 data slot
    wr(3'd1, 20'h12345);
    peek(3'd1, v); chk("R2 data readback", v, 20'h12345);
    peek(3'd4, v); chk("R2 flags", v, 20'h880);

    // R3 R4 R5 codec write
    wr(3'd0, 20'h05000);
    chk("R3 strobe high", req, 1);
    chk("R4 addr", addr, 7'h05);
    chk("R4 dir write", rd, 0);
    chk("R5 wdata", cwd, 16'h1234);
    peek(3'd4, v); chk("R3 flags", v, 20'h800);
    idle(1);
    chk("R3 strobe one cycle", req, 0);

    // R6 R7 codec read
    wr(3'd0, 20'h85000);
    chk("R4 dir read", rd, 1);
    peek(3'd4, v); chk("R7 busy set", v, 20'h805);
    idle(1);
    peek(3'd4, v); chk("R7 still busy", v, 20'h805);
    idle(1);
    peek(3'd2, v); chk("R6 rx1 echo", v, 20'h05000);
    peek(3'd3, v); chk("R6 rx2 result", v, 20'h12340);
    peek(3'd4, v); chk("R7 valid set", v, 20'h940);

    // R8 acknowledge
    ack(3'd2, v); chk("R8 rx1 data", v, 20'h05000);
    peek(3'd4, v); chk("R8 clear bit6", v, 20'h900);
    ack(3'd3, v); chk("R8 rx2 data", v, 20'h12340);
    peek(3'd4, v); chk("R8 clear bit8", v, 20'h800);

    // R9 blocked in strobe cycle
    e10 = mem[10];
    wr(3'd0, 20'h8A000);
    wr(3'd0, 20'h03000);
    chk("R9 no strobe (strobe cycle)", req, 0);
    peek(3'd0, v); chk("R9 cmd kept", v, 20'h8A000);
    idle(1);
    peek(3'd2, v); chk("R6 rx1 addr 0A", v, 20'h0A000);
    peek(3'd3, v); chk("R6 rx2 addr 0A", v, {e10, 4'h0});

    // R9 blocked in response wait cycle
    wr(3'd0, 20'h8B000);
    idle(1);
    wr(3'd0, 20'h07000);
    chk("R9 no strobe (wait cycle)", req, 0);
    peek(3'd0, v); chk("R9 cmd kept wait", v, 20'h8B000);
    idle(2);

    // R8 capture outranks acknowledge
    ack(3'd2, v); ack(3'd3, v);
    peek(3'd4, v); chk("R8 both cleared", v, 20'h800);
    wr(3'd0, 20'h8C000);
    idle(1);
    ack(3'd2, v);
    peek(3'd4, v); chk("R8 capture wins", v & 20'h40, 20'h40);
    idle(1);

    // R4 R5 R6 extreme values
    wr(3'd1, 20'hFFFFF);
    wr(3'd0, 20'h7F000);
    chk("R4 addr 7F", addr, 7'h7F);
    chk("R5 wdata FFFF", cwd, 16'hFFFF);
    idle(1);
    wr(3'd0, 20'hFF000);
    idle(2);
    peek(3'd2, v); chk("R6 rx1 7F", v, 20'h7F000);
    peek(3'd3, v); chk("R6 rx2 FFFF", v, 20'hFFFF0);

    // R10 sticky transmit-empty bits
    idle(3);
    peek(3'd4, v); chk("R10 tx bits", v & 20'hA80, 20'h800);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    peek(3'd4, v); chk("R10 R1 after reset", v, 20'hA80);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule